// File: doc/BRIEF.md
# Converter Serial Frame Port

This block is the device-side serial port of a multichannel 12-bit sampling converter. An external controller frames each transfer with an active-low chip select and a serial clock. When chip select falls, the port issues a one-cycle hold strobe to the sampling front end. It also takes the output line out of high impedance and shows the first bit of the outgoing word at once. The word is a 4-bit channel tag followed by a 12-bit result, both most significant bit first. The tag and result come from a parallel input port and are latched on that same falling edge.

While the word goes out, the port shifts in a 16-bit control word from the serial data input. The control word is committed only when the frame reaches its 16th serial-clock falling edge and its first bit, the write flag, is 1. Releasing chip select early abandons the frame and leaves the control register as it was. The serial clock, chip select and data input are asynchronous to the system clock. They are synchronized and edge-detected, so all logic runs on the system clock, and the serial clock may be at most one quarter of the system clock rate. The data moves as a fixed-length frame set by the external clock, so there is no valid/ready handshake and no back-pressure. The serial master sets the pace, and the parallel result is simply sampled at frame start.

Top module: `adc_frame_port`

## Requirements
- R1: After reset the output enable is 0, no strobe is active and every control field output is 0.
- R2: A chip-select falling edge produces exactly one single-cycle hold strobe and raises the output enable. The data output then carries channel-tag bit 3 before any serial-clock falling edge.
- R3: Each serial-clock falling edge k (k = 1..15) moves the data output to bit 15-k of the word {tag[3:0], result[11:0]}.
- R4: The outgoing word is the tag and result present at the chip-select falling edge. Changes on the parallel inputs during the frame do not alter it.
- R5: The output enable drops on the 16th serial-clock falling edge of the frame.
- R6: Exactly one single-cycle track strobe is issued per frame, at the 14th serial-clock falling edge. None is issued if the frame ends earlier.
- R7: Serial input bits are captured on falling edges 1..16 into word w, with the first bit at w[15]. When w[15]=1 at the 16th edge the fields update: repeat = w[14], channel enable i = w[13-i] for i = 0..7, external reference = w[3], temperature sense = w[2], averaging = w[1], power-down = w[0].
- R8: A completed frame with w[15]=0 leaves every control field unchanged.
- R9: Raising chip select before the 16th falling edge drops the output enable and leaves every control field unchanged.
- R10: Bits w[5] and w[4] are reserved and have no effect on any control field output.
- R11: Serial-clock falling edges after the 16th, while chip select stays low, leave the output disabled and do not change the control fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the master (idles high) |
| cs_n_i | input | 1 | Active-low chip select |
| sdi_i | input | 1 | Serial control data input |
| res_chan_i | input | 4 | Channel tag of the current result |
| res_data_i | input | 12 | Current conversion result |
| sdo_o | output | 1 | Serial data output value |
| sdo_en_o | output | 1 | Output enable (0 means high impedance) |
| hold_pulse_o | output | 1 | Single-cycle sample/hold strobe at frame start |
| track_pulse_o | output | 1 | Single-cycle acquisition-start strobe at the 14th edge |
| cfg_rpt_o | output | 1 | Repeat-mode control field |
| cfg_chan_en_o | output | 8 | Per-channel enable control fields |
| cfg_ext_ref_o | output | 1 | External-reference select |
| cfg_temp_o | output | 1 | Temperature-sense enable |
| cfg_avg_o | output | 1 | Averaging enable |
| cfg_pdown_o | output | 1 | Partial power-down enable |

## Verification
On every cycle, the assertions check that the hold and track strobes last one cycle and that a hold strobe comes with the output enable. They also check that the bit counter stays within the frame length, that the outgoing shift word moves only on a load or a shift, and that the control register changes only on a commit. Only the bench's frames can show bit order and timing against the parallel inputs, the mapping of control bits to fields, and abort, write-flag-clear and reserved-bit cases. The same holds for the exact edge of the track strobe and for edges past the end of the frame. The bench sweeps every channel tag with arithmetic data and control patterns.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;
  localparam int CHAN_N = 8;
  localparam int CTRL_W = 16;

  typedef struct packed {
    logic              rpt_en;
    logic [CHAN_N-1:0] chan_en;
    logic              ext_ref;
    logic              temp_en;
    logic              avg_en;
    logic              pdown;
  } cfg_t;

  // Map a received control word onto the field set; w[15] is the write flag,
  // w[5:4] are reserved and not read.
  function automatic cfg_t decode_ctrl(input logic [CTRL_W-1:0] w);
    cfg_t c;
    c.rpt_en = w[14];
    for (int i = 0; i < CHAN_N; i++) c.chan_en[i] = w[13-i];
    c.ext_ref = w[3];
    c.temp_en = w[2];
    c.avg_en  = w[1];
    c.pdown   = w[0];
    return c;
  endfunction
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= chain[STAGES-1];

  assign level_o = chain[STAGES-1];
  assign rise_o  = chain[STAGES-1] & ~prev_q;
  assign fall_o  = ~chain[STAGES-1] & prev_q;
endmodule

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int FRAME_LEN = 16,
  parameter int ACQ_EDGE  = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic edge_i,
  output logic active_o,
  output logic shift_o,
  output logic hold_o,
  output logic acq_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_M1 = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] ACQ_M1  = CNT_W'(ACQ_EDGE - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  assign shift_o  = edge_i & active_q & ~stop_i;
  assign active_o = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      hold_o   <= 1'b0;
      acq_o    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      hold_o <= 1'b0;
      acq_o  <= 1'b0;
      done_o <= 1'b0;
      if (stop_i) begin
        active_q <= 1'b0;
      end else if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        hold_o   <= 1'b1;
      end else if (shift_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == ACQ_M1) acq_o <= 1'b1;
        if (cnt_q == LAST_M1) begin
          active_q <= 1'b0;
          done_o   <= 1'b1;
        end
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FRAME_LEN)); // R5
  AST_DONE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !active_q); // R5
  AST_HOLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |=> !hold_o); // R2
  AST_HOLD_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> active_q); // R2
  AST_ACQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    acq_o |=> !acq_o); // R6
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] word_i,
  input  logic             shift_i,
  output logic             bit_o
);
  logic [WIDTH-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       sh_q <= '0;
    else if (load_i)  sh_q <= word_i;
    else if (shift_i) sh_q <= {sh_q[WIDTH-2:0], 1'b0};

  assign bit_o = sh_q[WIDTH-1];

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !shift_i) |=> $stable(sh_q)); // R4
endmodule

// File: rtl/ctrl_capture.sv
module ctrl_capture
  import adc_frame_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic shift_i,
  input  logic bit_i,
  input  logic done_i,
  output cfg_t cfg_o
);
  logic [CTRL_W-1:0] rx_q;
  cfg_t              cfg_q;
  logic              commit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       rx_q <= '0;
    else if (shift_i) rx_q <= {rx_q[CTRL_W-2:0], bit_i};

  assign commit = done_i & rx_q[CTRL_W-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cfg_q <= '0;
    else if (commit) cfg_q <= decode_ctrl(rx_q);

  assign cfg_o = cfg_q;

  AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cfg_q)); // R8
endmodule

// File: rtl/adc_frame_port.sv
module adc_frame_port
  import adc_frame_pkg::*;
#(
  parameter int TAG_W       = 4,
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int ACQ_EDGE    = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              sdi_i,
  input  logic [TAG_W-1:0]  res_chan_i,
  input  logic [DATA_W-1:0] res_data_i,
  output logic              sdo_o,
  output logic              sdo_en_o,
  output logic              hold_pulse_o,
  output logic              track_pulse_o,
  output logic              cfg_rpt_o,
  output logic [CHAN_N-1:0] cfg_chan_en_o,
  output logic              cfg_ext_ref_o,
  output logic              cfg_temp_o,
  output logic              cfg_avg_o,
  output logic              cfg_pdown_o
);
  localparam int FRAME_LEN = TAG_W + DATA_W;

  logic sclk_lvl, sclk_rise, sclk_fall;
  logic cs_lvl, cs_rise, cs_fall;
  logic sdi_lvl, sdi_rise, sdi_fall;
  logic shift, done, active;
  cfg_t cfg;

  edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk (
    .clk(clk), .rst_n(rst_n), .async_i(sclk_i),
    .level_o(sclk_lvl), .rise_o(sclk_rise), .fall_o(sclk_fall));
  edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs (
    .clk(clk), .rst_n(rst_n), .async_i(cs_n_i),
    .level_o(cs_lvl), .rise_o(cs_rise), .fall_o(cs_fall));
  edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sdi (
    .clk(clk), .rst_n(rst_n), .async_i(sdi_i),
    .level_o(sdi_lvl), .rise_o(sdi_rise), .fall_o(sdi_fall));

  frame_seq #(.FRAME_LEN(FRAME_LEN), .ACQ_EDGE(ACQ_EDGE)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_i(cs_fall), .stop_i(cs_rise), .edge_i(sclk_fall),
    .active_o(active), .shift_o(shift),
    .hold_o(hold_pulse_o), .acq_o(track_pulse_o), .done_o(done));

  tx_shifter #(.WIDTH(FRAME_LEN)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .load_i(cs_fall), .word_i({res_chan_i, res_data_i}),
    .shift_i(shift), .bit_o(sdo_o));

  ctrl_capture u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .shift_i(shift), .bit_i(sdi_lvl), .done_i(done), .cfg_o(cfg));

  assign sdo_en_o      = active;
  assign cfg_rpt_o     = cfg.rpt_en;
  assign cfg_chan_en_o = cfg.chan_en;
  assign cfg_ext_ref_o = cfg.ext_ref;
  assign cfg_temp_o    = cfg.temp_en;
  assign cfg_avg_o     = cfg.avg_en;
  assign cfg_pdown_o   = cfg.pdown;

  logic unused_edges;
  assign unused_edges = sclk_lvl ^ cs_lvl ^ sdi_rise ^ sdi_fall ^ sclk_rise;

  AST_EN_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_en_o) |-> hold_pulse_o); // R2
  AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(hold_pulse_o && track_pulse_o)); // R6
endmodule

// File: tb/tb_adc_frame_port.sv
module tb_adc_frame_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, cs_n = 1'b1, sdi = 1'b0;
  logic [3:0]  chan = '0;
  logic [11:0] data = '0;
  logic sdo, sdo_en, hold_p, track_p;
  logic cfg_rpt, cfg_ext, cfg_temp, cfg_avg, cfg_pd;
  logic [7:0] cfg_ch;

  int checks = 0, errors = 0;
  int hold_cnt = 0, track_cnt = 0, track_at = 0, cur_fall = 0;
  bit done_flag = 0;
  logic [15:0] exp_cfg = '0;

  always #2 clk = ~clk;

  adc_frame_port dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .sdi_i(sdi),
    .res_chan_i(chan), .res_data_i(data),
    .sdo_o(sdo), .sdo_en_o(sdo_en), .hold_pulse_o(hold_p), .track_pulse_o(track_p),
    .cfg_rpt_o(cfg_rpt), .cfg_chan_en_o(cfg_ch), .cfg_ext_ref_o(cfg_ext),
    .cfg_temp_o(cfg_temp), .cfg_avg_o(cfg_avg), .cfg_pdown_o(cfg_pd));

  always @(posedge clk) begin
    if (hold_p) hold_cnt++;
    if (track_p) begin track_cnt++; track_at = cur_fall; end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cfg_word();
    logic [15:0] w = '0;
    w[14] = cfg_rpt;
    for (int i = 0; i < 8; i++) w[13-i] = cfg_ch[i];
    w[3] = cfg_ext; w[2] = cfg_temp; w[1] = cfg_avg; w[0] = cfg_pd;
    return w;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nclk: falling edges before chip select rises; extra edges beyond 16 allowed (R11)
  task automatic frame(input logic [3:0] t, input logic [11:0] d, input logic [15:0] ctl, input int nclk);
    logic [15:0] word = {t, d};
    chan = t; data = d;
    hold_cnt = 0; track_cnt = 0; track_at = 0; cur_fall = 0;
    wait_clk(2);
    cs_n = 1'b0;
    wait_clk(8);
    chk(hold_cnt == 1, "R2 hold strobe count", hold_cnt, 1);
    chk(sdo_en === 1'b1, "R2 enable at start", sdo_en, 1);
    chk(sdo === t[3], "R2 first tag bit", sdo, t[3]);
    chan = ~t; data = d ^ 12'hA5C;  // R4: inputs move during the frame
    for (int k = 1; k <= nclk; k++) begin
      sdi = (k <= 16) ? ctl[16-k] : ~sdi;
      wait_clk(4);
      sclk = 1'b0; cur_fall = k;
      wait_clk(8);
      if (k < 16) begin
        chk(sdo_en === 1'b1, "R3 enable mid-frame", sdo_en, 1);
        chk(sdo === word[15-k], "R3/R4 output bit", sdo, word[15-k]);
      end else begin
        chk(sdo_en === 1'b0, (k == 16) ? "R5 disable at 16th edge" : "R11 extra edge", sdo_en, 0);
      end
      sclk = 1'b1;
      wait_clk(8);
    end
    cs_n = 1'b1;
    wait_clk(8);
    chk(sdo_en === 1'b0, "R9 disabled after release", sdo_en, 0);
    if (nclk >= 16 && ctl[15]) exp_cfg = ctl & 16'h7FCF;
    chk(cfg_word() === exp_cfg, "R7/R8/R9/R10/R11 control fields", cfg_word(), exp_cfg);
    chk(track_cnt == ((nclk >= 14) ? 1 : 0), "R6 track strobe count", track_cnt, (nclk >= 14) ? 1 : 0);
    if (nclk >= 14) chk(track_at == 14, "R6 track edge", track_at, 14);
  endtask

  initial begin
    wait_clk(3);
    chk(sdo_en === 1'b0, "R1 enable after reset", sdo_en, 0);
    chk(hold_p === 1'b0 && track_p === 1'b0, "R1 strobes after reset", {hold_p, track_p}, 0);
    chk(cfg_word() === 16'h0, "R1 control after reset", cfg_word(), 0);
    rst_n = 1'b1;
    wait_clk(4);
    for (int c = 0; c < 16; c++) begin
      logic [15:0] ctl = 16'((c * 40503) ^ 16'h3C96);
      ctl[15] = (c % 3 != 2);  // R8: every third frame has the write flag clear
      frame(4'(c), 12'((c * 273 + 1443) & 12'hFFF), ctl, 16);
    end
    frame(4'hA, 12'h800, 16'hFFFF, 16);   // R10: reserved bits set
    frame(4'h5, 12'h001, 16'h8030, 16);   // R10: only reserved bits besides write
    frame(4'h3, 12'h7FE, 16'hC1E5, 10);   // R9: abort before track edge
    frame(4'hC, 12'hF0F, 16'hBEEF, 15);   // R9: abort after track edge
    frame(4'h9, 12'h555, 16'hA30A, 19);   // R11: edges past the frame
    frame(4'h6, 12'hAAA, 16'h0FFF, 16);   // R8: write flag clear
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule